// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is a synchronous model of the command front end of a parallel NOR flash. Each clock it may see one bus write, which carries an address, a data word and the byte/word flag. It matches these writes against the unlock-prefixed command sequences. From them it tracks the mode the part is in, answers identification reads, and hands program and erase jobs to an external controller by way of one-cycle start pulses.

The array itself, timing and status-bit encoding belong to the controller. The controller reports completion through `ctl_done` and reports failure through `ctl_error`. Blocks are indexed by address bits A12..A18, which gives 128 uniform blocks at the default parameters. A per-block protection vector comes in from outside.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `mode` is 0 (read), all four pulse outputs are low and `id_data` is 0.
- R2: Only the low address bits and data bits 7:0 take part in matching. In word mode these are bits 10:0, and the two unlock writes are AAh to 555h and then 55h to 2AAh. In byte mode these are bits 11:0 (bit 0 is the half-word select), and the unlock addresses are AAAh and 555h. All higher bits are ignored.
- R3: The unlock pair followed by 90h at the first unlock address gives `mode` 1 (identify). The mode persists until another write arrives. In it, `id_data` depends on A1A0. A1A0=00 returns 0020h. A1A0=01 returns `DEV_CODE`. A1A0=10 returns 0001h if the block named by `rd_addr` is protected and 0000h if not. A1A0 sit at bits 1:0 in word mode and bits 2:1 in byte mode. The block index is bits 18:12 in word mode and 19:13 in byte mode. Outside mode 1, `id_data` is 0.
- R4: The unlock pair, then A0h at the first unlock address, then any write to an unprotected block gives a one-cycle `start_program`. This pulse carries that write's address and data on `op_addr`/`op_data`, and `mode` becomes 2 (busy). If the target is protected, no pulse is issued and `mode` returns to 0.
- R5: The unlock pair, 80h, the unlock pair, then 10h at the first unlock address gives a one-cycle `start_erase` with `erase_mask` equal to the inverse of `protect_mask`. `mode` becomes 2.
- R6: Replacing the sixth write with 30h to any address opens a window of `WIN_CYC` cycles, during which `mode` is 2. Each further 30h write adds its block and restarts the window. On expiry, `start_erase` fires with the collected mask, from which protected blocks are left out. If that mask is empty, `mode` returns to 0 with no pulse. Any other write inside the window abandons the erase and gives `mode` 0.
- R7: A B0h write during an erase gives a one-cycle `erase_suspend`, and `mode` becomes 4. While suspended, only a 30h write has any effect: it gives a one-cycle `erase_resume` and returns `mode` to 2. `ctl_done` is ignored while suspended.
- R8: F0h as a lone write, or F0h after the unlock pair, returns `mode` to 0 from identify or error.
- R9: In read or identify mode, a write that does not continue a valid sequence returns `mode` to 0.
- R10: While a program or erase runs, every write is ignored except B0h during an erase. `ctl_done` ends the job with `mode` 3 (error) if `ctl_error` is high, and with `mode` 0 otherwise.
- R11: In error mode, every write other than a read/reset leaves `mode` at 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle bus-write strobe |
| wr_addr | input | ADDR_W | Write address (byte or word address per `byte_mode`) |
| wr_data | input | 16 | Write data |
| byte_mode | input | 1 | 1 = byte addressing, 0 = word addressing |
| rd_addr | input | ADDR_W | Address of the current read, used for identification |
| id_data | output | 16 | Identification read data |
| protect_mask | input | 2**BLK_W | Per-block protection flags |
| ctl_done | input | 1 | Controller finished the current job |
| ctl_error | input | 1 | Qualifies `ctl_done` as a failure |
| mode | output | 3 | 0 read, 1 identify, 2 busy, 3 error, 4 suspended |
| start_program | output | 1 | Program start pulse |
| start_erase | output | 1 | Erase start pulse |
| erase_suspend | output | 1 | Suspend request pulse |
| erase_resume | output | 1 | Resume request pulse |
| op_addr | output | ADDR_W | Program target address |
| op_data | output | 16 | Program data |
| erase_mask | output | 2**BLK_W | Blocks to erase |

## Verification
The hardest state to reach is a suspended block erase whose mask was built from several appended writes, some of which named protected blocks. Getting there takes a six-write prefix, appends spaced inside the restarting window, the window's silent expiry, and then a suspend. The stimulus walks that path in byte mode. It pulses `ctl_done` during the suspension to show that it is ignored, and finishes only after the resume. The reference model tracks the window counter cycle by cycle, so an expiry that is off by one shows up on the erase pulse.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 20,
  parameter int BLK_W = 7,
  parameter int WIN_CYC = 16,
  parameter logic [15:0] DEV_CODE = 16'h00A5,
  parameter logic [15:0] MFR_CODE = 16'h0020
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [15:0]           wr_data,
  input  logic                  byte_mode,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [15:0]           id_data,
  input  logic [(1<<BLK_W)-1:0] protect_mask,
  input  logic                  ctl_done,
  input  logic                  ctl_error,
  output logic [2:0]            mode,
  output logic                  start_program,
  output logic                  start_erase,
  output logic                  erase_suspend,
  output logic                  erase_resume,
  output logic [ADDR_W-1:0]     op_addr,
  output logic [15:0]           op_data,
  output logic [(1<<BLK_W)-1:0] erase_mask
);
  localparam int NBLK = 1 << BLK_W;
  localparam int TW = $clog2(WIN_CYC + 1);

  typedef enum logic [2:0] {S_READ, S_ASEL, S_ERR, S_PGM, S_WIN, S_ERASE, S_SUSP} st_t;
  typedef enum logic [2:0] {Q_IDLE, Q_U1, Q_U2, Q_PGM, Q_E1, Q_E2, Q_E3} seq_t;

  st_t st;
  seq_t seq;
  logic [TW-1:0] tmr;

  wire [7:0] cd = wr_data[7:0];
  wire [11:0] key = byte_mode ? wr_addr[11:0] : {1'b0, wr_addr[10:0]};
  wire at_u1 = key == (byte_mode ? 12'hAAA : 12'h555);
  wire at_u2 = key == (byte_mode ? 12'h555 : 12'h2AA);
  wire [BLK_W-1:0] wr_blk = byte_mode ? wr_addr[13 +: BLK_W] : wr_addr[12 +: BLK_W];
  wire [NBLK-1:0] blk_bit = {{(NBLK-1){1'b0}}, 1'b1} << wr_blk;
  wire wr_prot = protect_mask[wr_blk];
  wire st_t bad_st = (st == S_ERR && cd != 8'hF0) ? S_ERR : S_READ;

  wire rd_a0 = byte_mode ? rd_addr[1] : rd_addr[0];
  wire rd_a1 = byte_mode ? rd_addr[2] : rd_addr[1];
  wire [BLK_W-1:0] rd_blk = byte_mode ? rd_addr[13 +: BLK_W] : rd_addr[12 +: BLK_W];

  always_comb begin
    case (st)
      S_READ:  mode = 3'd0;
      S_ASEL:  mode = 3'd1;
      S_ERR:   mode = 3'd3;
      S_SUSP:  mode = 3'd4;
      default: mode = 3'd2;
    endcase
  end

  always_comb begin
    id_data = 16'h0000;
    if (st == S_ASEL) begin
      case ({rd_a1, rd_a0})
        2'b00:   id_data = MFR_CODE;
        2'b01:   id_data = DEV_CODE;
        2'b10:   id_data = {15'd0, protect_mask[rd_blk]};
        default: id_data = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_READ;
      seq <= Q_IDLE;
      tmr <= '0;
      start_program <= 1'b0;
      start_erase <= 1'b0;
      erase_suspend <= 1'b0;
      erase_resume <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
      erase_mask <= '0;
    end else begin
      start_program <= 1'b0;
      start_erase <= 1'b0;
      erase_suspend <= 1'b0;
      erase_resume <= 1'b0;
      case (st)
        S_PGM: begin
          if (ctl_done) st <= ctl_error ? S_ERR : S_READ;
        end
        S_ERASE: begin
          if (ctl_done) st <= ctl_error ? S_ERR : S_READ;
          else if (wr_en && cd == 8'hB0) begin
            st <= S_SUSP;
            erase_suspend <= 1'b1;
          end
        end
        S_SUSP: begin
          if (wr_en && cd == 8'h30) begin
            st <= S_ERASE;
            erase_resume <= 1'b1;
          end
        end
        S_WIN: begin
          if (wr_en) begin
            if (cd == 8'h30) begin
              if (!wr_prot) erase_mask <= erase_mask | blk_bit;
              tmr <= '0;
            end else begin
              st <= S_READ;
            end
          end else if (tmr == TW'(WIN_CYC - 1)) begin
            if (|erase_mask) begin
              st <= S_ERASE;
              start_erase <= 1'b1;
            end else begin
              st <= S_READ;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          if (wr_en) begin
            seq <= Q_IDLE;
            case (seq)
              Q_IDLE: begin
                if (cd == 8'hAA && at_u1) seq <= Q_U1;
                else st <= bad_st;
              end
              Q_U1: begin
                if (cd == 8'h55 && at_u2) seq <= Q_U2;
                else st <= bad_st;
              end
              Q_U2: begin
                if (st != S_ERR && at_u1 && cd == 8'h90) st <= S_ASEL;
                else if (st != S_ERR && at_u1 && cd == 8'hA0) seq <= Q_PGM;
                else if (st != S_ERR && at_u1 && cd == 8'h80) seq <= Q_E1;
                else st <= bad_st;
              end
              Q_PGM: begin
                if (wr_prot) st <= S_READ;
                else begin
                  st <= S_PGM;
                  start_program <= 1'b1;
                  op_addr <= wr_addr;
                  op_data <= wr_data;
                end
              end
              Q_E1: begin
                if (cd == 8'hAA && at_u1) seq <= Q_E2;
                else st <= bad_st;
              end
              Q_E2: begin
                if (cd == 8'h55 && at_u2) seq <= Q_E3;
                else st <= bad_st;
              end
              Q_E3: begin
                if (cd == 8'h10 && at_u1) begin
                  erase_mask <= ~protect_mask;
                  if (&protect_mask) st <= S_READ;
                  else begin
                    st <= S_ERASE;
                    start_erase <= 1'b1;
                  end
                end else if (cd == 8'h30) begin
                  erase_mask <= wr_prot ? '0 : blk_bit;
                  tmr <= '0;
                  st <= S_WIN;
                end else begin
                  st <= bad_st;
                end
              end
              default: st <= bad_st;
            endcase
          end
        end
      endcase
    end
  end
endmodule

module flash_cmd_decoder_chk #(
  parameter int NBLK = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [15:0]     wr_data,
  input logic [2:0]      mode,
  input logic            start_program,
  input logic            start_erase,
  input logic            erase_suspend,
  input logic            erase_resume,
  input logic [NBLK-1:0] erase_mask,
  input logic [15:0]     id_data
);
  assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_program, start_erase, erase_suspend, erase_resume}));
  assert_pgm_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_program |-> mode == 3'd2);
  assert_erase_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_erase |-> (mode == 3'd2 && erase_mask != '0));
  assert_suspend_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_suspend |-> mode == 3'd4);
  assert_resume_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_resume |-> mode == 3'd2);
  assert_susp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !(wr_en && wr_data[7:0] == 8'h30)) |=> mode == 3'd4);
  assert_id_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 3'd1 |-> id_data == 16'h0000);
  assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && !wr_en) |=> mode == 3'd3);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.NBLK(NBLK)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mode(mode),
  .start_program(start_program), .start_erase(start_erase),
  .erase_suspend(erase_suspend), .erase_resume(erase_resume),
  .erase_mask(erase_mask), .id_data(id_data)
);

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  localparam int AW = 20;
  localparam int BW = 7;
  localparam int NB = 1 << BW;
  localparam int WIN = 16;
  localparam logic [15:0] DEV = 16'h00A5;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, byte_mode = 0, ctl_done = 0, ctl_error = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [NB-1:0] protect_mask = 0;
  logic [15:0] id_data, op_data;
  logic [2:0] mode;
  logic start_program, start_erase, erase_suspend, erase_resume;
  logic [AW-1:0] op_addr;
  logic [NB-1:0] erase_mask;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .BLK_W(BW), .WIN_CYC(WIN), .DEV_CODE(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .byte_mode(byte_mode), .rd_addr(rd_addr), .id_data(id_data),
    .protect_mask(protect_mask), .ctl_done(ctl_done), .ctl_error(ctl_error),
    .mode(mode), .start_program(start_program), .start_erase(start_erase),
    .erase_suspend(erase_suspend), .erase_resume(erase_resume),
    .op_addr(op_addr), .op_data(op_data), .erase_mask(erase_mask));

  int checks = 0, errors = 0;
  string req = "R1";
  int n_sp = 0, n_se = 0, n_sus = 0, n_res = 0;
  logic [NB-1:0] last_mask = 0;

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // reference model: 0 read,1 ident,2 error,3 program,4 window,5 erase,6 suspended
  int m_st = 0, m_seq = 0, m_tmr = 0;
  logic [NB-1:0] m_mask = 0;
  bit m_sp, m_se, m_sus, m_res;
  logic [AW-1:0] m_opa = 0;
  logic [15:0] m_opd = 0;

  function automatic int blk_of(input logic [AW-1:0] a, input bit bm);
    return bm ? int'(a[19:13]) : int'(a[18:12]);
  endfunction

  always @(posedge clk) begin
    int k, b;
    bit u1, u2, badw;
    logic [7:0] d;
    m_sp = 0; m_se = 0; m_sus = 0; m_res = 0;
    if (!rst_n) begin
      m_st = 0; m_seq = 0; m_tmr = 0; m_mask = 0; m_opa = 0; m_opd = 0;
    end else begin
      d = wr_data[7:0];
      k = byte_mode ? int'(wr_addr[11:0]) : int'(wr_addr[10:0]);
      u1 = byte_mode ? (k == 'hAAA) : (k == 'h555);
      u2 = byte_mode ? (k == 'h555) : (k == 'h2AA);
      b = blk_of(wr_addr, byte_mode);
      if (m_st == 3) begin
        if (ctl_done) m_st = ctl_error ? 2 : 0;
      end else if (m_st == 5) begin
        if (ctl_done) m_st = ctl_error ? 2 : 0;
        else if (wr_en && d == 8'hB0) begin m_st = 6; m_sus = 1; end
      end else if (m_st == 6) begin
        if (wr_en && d == 8'h30) begin m_st = 5; m_res = 1; end
      end else if (m_st == 4) begin
        if (wr_en) begin
          if (d == 8'h30) begin
            if (!protect_mask[b]) m_mask[b] = 1'b1;
            m_tmr = 0;
          end else m_st = 0;
        end else if (m_tmr == WIN - 1) begin
          if (m_mask != 0) begin m_st = 5; m_se = 1; end
          else m_st = 0;
        end else m_tmr++;
      end else if (wr_en) begin
        badw = 0;
        case (m_seq)
          0: if (d == 8'hAA && u1) m_seq = 1; else badw = 1;
          1: if (d == 8'h55 && u2) m_seq = 2; else badw = 1;
          2: begin
            m_seq = 0;
            if (m_st != 2 && u1 && d == 8'h90) m_st = 1;
            else if (m_st != 2 && u1 && d == 8'hA0) m_seq = 3;
            else if (m_st != 2 && u1 && d == 8'h80) m_seq = 4;
            else badw = 1;
          end
          3: begin
            m_seq = 0;
            if (protect_mask[b]) m_st = 0;
            else begin m_st = 3; m_sp = 1; m_opa = wr_addr; m_opd = wr_data; end
          end
          4: if (d == 8'hAA && u1) m_seq = 5; else badw = 1;
          5: if (d == 8'h55 && u2) m_seq = 6; else badw = 1;
          default: begin
            m_seq = 0;
            if (d == 8'h10 && u1) begin
              m_mask = ~protect_mask;
              if (m_mask == 0) m_st = 0; else begin m_st = 5; m_se = 1; end
            end else if (d == 8'h30) begin
              m_mask = 0;
              if (!protect_mask[b]) m_mask[b] = 1'b1;
              m_tmr = 0; m_st = 4;
            end else badw = 1;
          end
        endcase
        if (badw) begin
          m_seq = 0;
          m_st = (m_st == 2 && d != 8'hF0) ? 2 : 0;
        end
      end
    end
  end

  function automatic logic [2:0] m_mode();
    case (m_st)
      0: return 3'd0;
      1: return 3'd1;
      2: return 3'd3;
      6: return 3'd4;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [15:0] m_id();
    bit a0, a1;
    if (m_st != 1) return 16'h0;
    a0 = byte_mode ? rd_addr[1] : rd_addr[0];
    a1 = byte_mode ? rd_addr[2] : rd_addr[1];
    if (!a1 && !a0) return 16'h0020;
    if (!a1 && a0) return DEV;
    if (a1 && !a0) return {15'd0, protect_mask[blk_of(rd_addr, byte_mode)]};
    return 16'h0;
  endfunction

  always begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      chk(mode == m_mode(), req, mode, m_mode());
      chk(start_program == m_sp, {req, "/R4"}, start_program, m_sp);
      chk(start_erase == m_se, {req, "/R5"}, start_erase, m_se);
      chk({erase_suspend, erase_resume} == {m_sus, m_res}, {req, "/R7"},
          {erase_suspend, erase_resume}, {m_sus, m_res});
      chk(id_data == m_id(), {req, "/R3"}, id_data, m_id());
      if (m_sp) chk(op_addr == m_opa && op_data == m_opd, "R4", {op_addr, op_data}, {m_opa, m_opd});
      if (m_se) chk(erase_mask == m_mask, "R6", erase_mask, m_mask);
      if (start_program) n_sp++;
      if (start_erase) begin n_se++; last_mask = erase_mask; end
      if (erase_suspend) n_sus++;
      if (erase_resume) n_res++;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic unlock();
    if (byte_mode) begin wr(20'hAAA, 16'h00AA); wr(20'h555, 16'h0055); end
    else begin wr(20'h555, 16'h00AA); wr(20'h2AA, 16'h0055); end
  endtask

  function automatic logic [AW-1:0] u1a();
    return byte_mode ? 20'hAAA : 20'h555;
  endfunction

  function automatic logic [AW-1:0] baddr(input int b);
    return byte_mode ? AW'(b) << 13 : AW'(b) << 12;
  endfunction

  task automatic done(input bit e);
    @(negedge clk);
    ctl_done = 1; ctl_error = e;
    @(negedge clk);
    ctl_done = 0; ctl_error = 0;
  endtask

  bit finished = 0;
  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sp0, se0;
    protect_mask[5] = 1; protect_mask[100] = 1; protect_mask[77] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mode == 0, "R1", mode, 0);
    chk({start_program, start_erase, erase_suspend, erase_resume} == 0, "R1",
        {start_program, start_erase, erase_suspend, erase_resume}, 0);
    chk(id_data == 0, "R1", id_data, 0);

    req = "R3";
    wr(20'hF8555, 16'h12AA); wr(20'h3A2AA, 16'hFF55); wr(20'h40555, 16'h0090);
    chk(mode == 1, "R2", mode, 1);
    rd_addr = 20'h12340; @(negedge clk);
    chk(id_data == 16'h0020, "R3", id_data, 16'h0020);
    rd_addr = 20'h00001; @(negedge clk);
    chk(id_data == DEV, "R3", id_data, DEV);
    rd_addr = (20'd5 << 12) | 20'h2; @(negedge clk);
    chk(id_data == 16'h0001, "R3", id_data, 1);
    rd_addr = (20'd6 << 12) | 20'h2; @(negedge clk);
    chk(id_data == 16'h0000, "R3", id_data, 0);
    repeat (20) @(negedge clk);
    chk(mode == 1, "R3", mode, 1);

    req = "R8";
    wr(20'h01234, 16'h00F0);
    chk(mode == 0, "R8", mode, 0);

    req = "R4";
    sp0 = n_sp;
    unlock(); wr(20'h555, 16'h00A0); wr(20'h34567, 16'hBEEF);
    chk(n_sp == sp0 + 1, "R4", n_sp, sp0 + 1);
    chk(op_addr == 20'h34567 && op_data == 16'hBEEF, "R4", {op_addr, op_data}, {20'h34567, 16'hBEEF});
    req = "R10";
    wr(20'h0, 16'h00F0); unlock(); wr(20'h555, 16'h00A0); wr(20'h1000, 16'h0000);
    chk(mode == 2 && n_sp == sp0 + 1, "R10", {mode, n_sp}, {3'd2, sp0 + 1});
    done(0);
    chk(mode == 0, "R10", mode, 0);

    req = "R4";
    unlock(); wr(20'h555, 16'h00A0); wr(baddr(5) | 20'h10, 16'h1234);
    chk(mode == 0 && n_sp == sp0 + 1, "R4", {mode, n_sp}, {3'd0, sp0 + 1});

    req = "R10";
    unlock(); wr(20'h555, 16'h00A0); wr(20'h2000, 16'h0F0F);
    done(1);
    chk(mode == 3, "R10", mode, 3);
    req = "R11";
    wr(20'h0, 16'h0030); unlock(); wr(20'h555, 16'h0090);
    chk(mode == 3, "R11", mode, 3);
    req = "R8";
    unlock(); wr(20'h777, 16'h00F0);
    chk(mode == 0, "R8", mode, 0);

    req = "R5";
    byte_mode = 1;
    se0 = n_se;
    unlock(); wr(20'hAAA, 16'h0080); unlock(); wr(20'hAAA, 16'h0010);
    chk(n_se == se0 + 1 && last_mask == ~protect_mask, "R5", last_mask, ~protect_mask);
    done(0);
    chk(mode == 0, "R5", mode, 0);

    req = "R6";
    unlock(); wr(u1a(), 16'h0080); unlock(); wr(baddr(9) | 20'h3, 16'h0030);
    wr(baddr(5), 16'h0030); wr(baddr(20) | 20'h77, 16'h0030);
    chk(mode == 2 && n_se == se0 + 1, "R6", {mode, n_se}, {3'd2, se0 + 1});
    repeat (WIN + 2) @(negedge clk);
    chk(n_se == se0 + 2 && last_mask == ((NB'(1) << 9) | (NB'(1) << 20)), "R6",
        last_mask, (NB'(1) << 9) | (NB'(1) << 20));
    req = "R7";
    wr(20'h0, 16'h00B0);
    chk(mode == 4 && n_sus == 1, "R7", {mode, n_sus}, {3'd4, 1});
    done(0); wr(20'h0, 16'h00F0);
    chk(mode == 4, "R7", mode, 4);
    wr(20'h0, 16'h0030);
    chk(mode == 2 && n_res == 1, "R7", {mode, n_res}, {3'd2, 1});
    done(0);
    chk(mode == 0, "R10", mode, 0);

    req = "R6";
    unlock(); wr(u1a(), 16'h0080); unlock(); wr(baddr(100), 16'h0030);
    repeat (WIN + 2) @(negedge clk);
    chk(mode == 0 && n_se == se0 + 2, "R6", {mode, n_se}, {3'd0, se0 + 2});
    unlock(); wr(u1a(), 16'h0080); unlock(); wr(baddr(1), 16'h0030); wr(20'h0, 16'h0055);
    chk(mode == 0, "R6", mode, 0);
    repeat (WIN + 2) @(negedge clk);
    chk(n_se == se0 + 2, "R6", n_se, se0 + 2);

    req = "R2";
    wr(20'h555, 16'h00AA); wr(20'h2AA, 16'h0055); wr(20'h555, 16'h0090);
    chk(mode == 0, "R2", mode, 0);
    unlock(); wr(20'hAAA, 16'h0090);
    rd_addr = 20'h00002; @(negedge clk);
    chk(mode == 1 && id_data == DEV, "R2", id_data, DEV);

    req = "R9";
    wr(20'hAAA, 16'h00AA); wr(20'h0, 16'h0000);
    chk(mode == 0, "R9", mode, 0);
    byte_mode = 0;
    unlock(); wr(20'h555, 16'h0077);
    chk(mode == 0, "R9", mode, 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule